// File: doc/BRIEF.md
# Instruction Operand Addressing Unit

This unit sits between instruction fetch and execute. It takes a 16-bit basic instruction word and works out what its two operand fields refer to. Each field can name a general register, a memory word reached through a register, the stack, a special register (SP, PC, EX) or a literal. When an operand needs an extra instruction word or a memory value, the unit reads it over a synchronous memory port with one cycle of read latency. PC moves forward by one for every extra word that is consumed. SP moves for the stack codes.

The unit resolves the source field (`a`, bits 15:10) completely before the destination field (`b`, bits 9:5). At the end it presents four things to the execute stage:
- the value of `a`;
- the current value of `b`;
- a write target for `b`, given as a kind, an address and a writable flag;
- the updated PC and SP.

The unit holds all of these until the execute stage acknowledges them. One instruction is in flight at a time. A new word is accepted only while `ready` is high.

Top module: `operand_addr_unit`

## Requirements
- R1: After reset `ready` is 1, and `valid`, `mem_req`, `pc_out` and `sp_out` are 0.
- R2: Field `a` is instr[15:10] and field `b` is instr[9:5]. When both fields need an extra word, `a` takes the word at PC and `b` takes the word at PC+1.
- R3: Codes 0x00-0x07 give the value of register code[2:0]. As `b` they report kind 0 (register), address = register index, writable 1.
- R4: Codes 0x08-0x0f give memory at the address held in register code[2:0]. As `b` they report kind 1 (memory), address = that address.
- R5: Codes 0x10-0x17 address register+next word, 0x1a addresses SP+next word and 0x1e addresses the next word. Each extra word is read at the current PC, and PC then increments. `pc_out` = `pc_in` + number of extra words.
- R6: Code 0x18 as `a` reads memory[SP] and then increments SP. As `b` it decrements SP and then addresses memory[SP]. SP wraps modulo 2^16.
- R7: Code 0x19 addresses memory[SP] and leaves SP unchanged.
- R8: Code 0x1b gives the current SP (kind 2), 0x1c the current PC after any extra words taken so far (kind 3), and 0x1d the EX value captured at start (kind 4). All three are writable as `b`, with address 0.
- R9: Code 0x1f gives the next word as a literal. Codes 0x20-0x3f (only in `a`) give (code - 0x21) mod 2^16, which is 0xffff for 0x20 and 30 for 0x3f.
- R10: A `b` operand that is a literal (0x1f) reports kind 5, address 0 and writable 0.
- R11: While `valid` is high and `ack` is low, all results are held. SP changes only once per instruction, however long the stall lasts. `ready` is low while `valid` is high.
- R12: Each memory read is a single-cycle `mem_req`, and its data is taken from `mem_rdata` in the following cycle. No request is issued in that following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Instruction offered |
| ready | output | 1 | Unit idle, start accepted |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | PC pointing after the instruction word |
| sp_in | input | 16 | Stack pointer |
| ex_in | input | 16 | Excess register value |
| reg_sel | output | 3 | Register file read index |
| reg_rdata | input | 16 | Register file read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, one cycle after request |
| valid | output | 1 | Results ready for execute |
| ack | input | 1 | Execute accepts results |
| a_value | output | 16 | Source operand value |
| b_value | output | 16 | Destination operand current value |
| b_addr | output | 16 | Register index or memory address of b |
| b_kind | output | 3 | 0 reg, 1 mem, 2 SP, 3 PC, 4 EX, 5 literal |
| b_writable | output | 1 | b may be written back |
| pc_out | output | 16 | Updated PC |
| sp_out | output | 16 | Updated SP |

## Verification
The assertions assume three things about the inputs:
- `start` is only acted on while `ready` is high.
- `mem_rdata` reflects the address requested in the previous cycle.
- `reg_rdata` follows `reg_sel` without delay and stays constant during an instruction.

The bench meets these by design. Its memory returns a pure function of the registered address. Its register file is a fixed function of the index. It raises `start` only after seeing `ready`, for one cycle, and holds `ack` low for a chosen number of cycles to exercise stalls.

// File: rtl/operand_addr_unit.sv
`timescale 1ns/1ps
module operand_addr_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         ready,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] ex_in,
  output logic [2:0]   reg_sel,
  input  logic [W-1:0] reg_rdata,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         valid,
  input  logic         ack,
  output logic [W-1:0] a_value,
  output logic [W-1:0] b_value,
  output logic [W-1:0] b_addr,
  output logic [2:0]   b_kind,
  output logic         b_writable,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] sp_out
);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_EXT, S_EXTW, S_MEM, S_MEMW, S_DONE} st_t;

  localparam logic [5:0] C_STK  = 6'h18;
  localparam logic [5:0] C_PEEK = 6'h19;
  localparam logic [5:0] C_PICK = 6'h1a;
  localparam logic [5:0] C_SP   = 6'h1b;
  localparam logic [5:0] C_PC   = 6'h1c;
  localparam logic [5:0] C_EX   = 6'h1d;
  localparam logic [5:0] C_IND  = 6'h1e;
  localparam logic [5:0] C_LIT  = 6'h1f;
  localparam logic [W-1:0] LIT_BIAS = W'(33);

  localparam logic [2:0] K_REG = 3'd0;
  localparam logic [2:0] K_MEM = 3'd1;
  localparam logic [2:0] K_SP  = 3'd2;
  localparam logic [2:0] K_PC  = 3'd3;
  localparam logic [2:0] K_EX  = 3'd4;
  localparam logic [2:0] K_LIT = 3'd5;

  st_t         st;
  logic [15:0] ir;
  logic        op;
  logic [W-1:0] pc_q, sp_q, ex_q, ea_q;

  logic [5:0]   field;
  logic         need_ext, need_mem, fin;
  logic [W-1:0] direct_val, fin_val, ext_base;
  logic [2:0]   cur_kind;

  assign field   = op ? {1'b0, ir[9:5]} : ir[15:10];
  assign reg_sel = field[2:0];

  assign need_ext = (field[5:3] == 3'b010) || field == C_PICK || field == C_IND || field == C_LIT;
  assign need_mem = (field[5:3] == 3'b001) || (field[5:3] == 3'b010) ||
                    field == C_STK || field == C_PEEK || field == C_PICK || field == C_IND;

  always_comb begin
    if (field[5])            direct_val = W'(field) - LIT_BIAS;
    else if (field == C_SP)  direct_val = sp_q;
    else if (field == C_PC)  direct_val = pc_q;
    else if (field == C_EX)  direct_val = ex_q;
    else                     direct_val = reg_rdata;
  end

  always_comb begin
    if (field[5:3] == 3'b000)             cur_kind = K_REG;
    else if (field == C_SP)               cur_kind = K_SP;
    else if (field == C_PC)               cur_kind = K_PC;
    else if (field == C_EX)               cur_kind = K_EX;
    else if (field == C_LIT || field[5])  cur_kind = K_LIT;
    else                                  cur_kind = K_MEM;
  end

  always_comb begin
    if (field == C_PICK)      ext_base = sp_q;
    else if (field == C_IND)  ext_base = '0;
    else                      ext_base = reg_rdata;
  end

  assign fin = (st == S_DEC && !need_ext && !need_mem) ||
               (st == S_EXTW && field == C_LIT) ||
               (st == S_MEMW);
  assign fin_val = (st == S_DEC) ? direct_val : mem_rdata;

  assign mem_req  = (st == S_EXT) || (st == S_MEM);
  assign mem_addr = (st == S_EXT) ? pc_q : ea_q;
  assign ready    = (st == S_IDLE);
  assign valid    = (st == S_DONE);
  assign pc_out   = pc_q;
  assign sp_out   = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ir         <= '0;
      op         <= 1'b0;
      pc_q       <= '0;
      sp_q       <= '0;
      ex_q       <= '0;
      ea_q       <= '0;
      a_value    <= '0;
      b_value    <= '0;
      b_addr     <= '0;
      b_kind     <= K_REG;
      b_writable <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ir   <= instr;
          pc_q <= pc_in;
          sp_q <= sp_in;
          ex_q <= ex_in;
          op   <= 1'b0;
          st   <= S_DEC;
        end
        S_DEC: begin
          if (field == C_STK) begin
            if (op) begin
              sp_q <= sp_q - W'(1);
              ea_q <= sp_q - W'(1);
            end else begin
              sp_q <= sp_q + W'(1);
              ea_q <= sp_q;
            end
            st <= S_MEM;
          end else if (need_ext) begin
            st <= S_EXT;
          end else if (need_mem) begin
            ea_q <= (field == C_PEEK) ? sp_q : reg_rdata;
            st   <= S_MEM;
          end
        end
        S_EXT: begin
          pc_q <= pc_q + W'(1);
          st   <= S_EXTW;
        end
        S_EXTW: if (field != C_LIT) begin
          ea_q <= ext_base + mem_rdata;
          st   <= S_MEM;
        end
        S_MEM:  st <= S_MEMW;
        S_MEMW: ;
        S_DONE: if (ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (fin) begin
        if (!op) begin
          a_value <= fin_val;
          op      <= 1'b1;
          st      <= S_DEC;
        end else begin
          b_value    <= fin_val;
          b_kind     <= cur_kind;
          b_writable <= (cur_kind != K_LIT);
          b_addr     <= (cur_kind == K_REG) ? W'(field[2:0]) :
                        (cur_kind == K_MEM) ? ea_q : '0;
          st         <= S_DONE;
        end
      end
    end
  end

endmodule

// File: rtl/operand_addr_unit_chk.sv
`timescale 1ns/1ps
module operand_addr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic [W-1:0] instr,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] sp_in,
  input logic         mem_req,
  input logic         valid,
  input logic         ack,
  input logic [W-1:0] b_addr,
  input logic         b_writable,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] sp_out
);

  logic [15:0]  h_ins;
  logic [W-1:0] h_pc, h_sp;
  logic [5:0]   h_a, h_b;
  logic [1:0]   n_ext;
  logic [W-1:0] sp_net;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ins <= '0;
      h_pc  <= '0;
      h_sp  <= '0;
    end else if (start && ready) begin
      h_ins <= instr;
      h_pc  <= pc_in;
      h_sp  <= sp_in;
    end
  end

  assign h_a = h_ins[15:10];
  assign h_b = {1'b0, h_ins[9:5]};

  function automatic logic ext_code(input logic [5:0] c);
    return (c >= 6'h10 && c <= 6'h17) || c == 6'h1a || c == 6'h1e || c == 6'h1f;
  endfunction

  assign n_ext  = 2'(ext_code(h_a)) + 2'(ext_code(h_b));
  assign sp_net = h_sp + ((h_a == 6'h18) ? W'(1) : W'(0)) - ((h_b == 6'h18) ? W'(1) : W'(0));

  AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);                                                  // R12
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pc_out == h_pc + W'(n_ext));                                  // R5
  AST_SP_NET: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> sp_out == sp_net);                                            // R6
  AST_LIT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && h_b == 6'h1f) |-> !b_writable);                               // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> valid && $stable(sp_out) && $stable(b_addr));       // R11
  AST_BUSY_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !ready);                                                      // R11

endmodule

bind operand_addr_unit operand_addr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .instr(instr),
  .pc_in(pc_in), .sp_in(sp_in), .mem_req(mem_req), .valid(valid), .ack(ack),
  .b_addr(b_addr), .b_writable(b_writable), .pc_out(pc_out), .sp_out(sp_out)
);

// File: tb/operand_addr_unit_tb.sv
`timescale 1ns/1ps
module operand_addr_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack = 1'b0;
  logic [15:0] instr = '0, pc_in = '0, sp_in = '0, ex_in = '0;
  logic [2:0]  reg_sel;
  logic [15:0] reg_rdata, mem_addr, mem_rdata, a_value, b_value, b_addr, pc_out, sp_out;
  logic        ready, mem_req, valid, b_writable;
  logic [2:0]  b_kind;
  logic [15:0] mem_q = '0;

  always #2.5 clk = ~clk;

  operand_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .instr(instr),
    .pc_in(pc_in), .sp_in(sp_in), .ex_in(ex_in), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .valid(valid), .ack(ack), .a_value(a_value),
    .b_value(b_value), .b_addr(b_addr), .b_kind(b_kind), .b_writable(b_writable),
    .pc_out(pc_out), .sp_out(sp_out)
  );

  function automatic logic [15:0] regf(input logic [2:0] i);
    return 16'h0200 + 16'h0111 * {13'd0, i};
  endfunction
  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a ^ 16'hA5C3) + 16'h0017;
  endfunction

  assign reg_rdata = regf(reg_sel);
  always @(posedge clk) if (mem_req) mem_q <= memf(mem_addr);
  assign mem_rdata = mem_q;

  typedef struct {
    logic [15:0] av, bv, ba, pc, sp;
    logic [2:0]  bk;
    logic        bw;
    int          stall;
    string       tag;
  } exp_t;

  exp_t exq[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic resolve(input logic [5:0] c, input bit isb, input logic [15:0] ex,
                         inout logic [15:0] pcc, inout logic [15:0] spc,
                         output logic [15:0] val, output logic [2:0] kind,
                         output logic [15:0] addr);
    logic [15:0] ext, ea;
    ext = '0; ea = '0; kind = 3'd1; addr = '0; val = '0;
    if ((c >= 6'h10 && c <= 6'h17) || c == 6'h1a || c == 6'h1e || c == 6'h1f) begin
      ext = memf(pcc);
      pcc = pcc + 16'd1;
    end
    if (c < 6'h08) begin
      val = regf(c[2:0]); kind = 3'd0; addr = {13'd0, c[2:0]};
    end else if (c >= 6'h20) begin
      val = {10'd0, c} - 16'd33; kind = 3'd5;
    end else begin
      case (c)
        6'h1b: begin val = spc; kind = 3'd2; end
        6'h1c: begin val = pcc; kind = 3'd3; end
        6'h1d: begin val = ex;  kind = 3'd4; end
        6'h1f: begin val = ext; kind = 3'd5; end
        default: begin
          if (c < 6'h10)       ea = regf(c[2:0]);
          else if (c < 6'h18)  ea = regf(c[2:0]) + ext;
          else if (c == 6'h18) begin
            if (isb) begin spc = spc - 16'd1; ea = spc; end
            else begin ea = spc; spc = spc + 16'd1; end
          end
          else if (c == 6'h19) ea = spc;
          else if (c == 6'h1a) ea = spc + ext;
          else                 ea = ext;
          val = memf(ea); addr = ea;
        end
      endcase
    end
  endtask

  task automatic drive(input logic [5:0] a, input logic [4:0] b, input logic [15:0] pc,
                       input logic [15:0] sp, input logic [15:0] ex, input int stall,
                       input string tag);
    exp_t e;
    logic [15:0] pcc, spc, v, ad;
    logic [2:0]  k;
    pcc = pc; spc = sp;
    resolve(a, 1'b0, ex, pcc, spc, v, k, ad);
    e.av = v;
    resolve({1'b0, b}, 1'b1, ex, pcc, spc, v, k, ad);
    e.bv = v; e.bk = k; e.ba = ad; e.bw = (k != 3'd5);
    e.pc = pcc; e.sp = spc; e.stall = stall; e.tag = tag;
    exq.push_back(e);
    while (!ready) @(negedge clk);
    instr = {a, b, 5'h01}; pc_in = pc; sp_in = sp; ex_in = ex;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  bit   seen = 0;
  int   stall_left = 0;
  exp_t cur;
  bit   prev_req = 0;
  int   req_viol = 0;
  int   cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_req && mem_req) req_viol++;
      prev_req = mem_req;
      if (valid) begin
        if (!seen) begin
          seen = 1;
          if (exq.size() == 0) begin
            chk(1'b0, "R11", "unexpected valid", 16'd1, 16'd0);
          end else begin
            cur = exq.pop_front();
            chk(a_value == cur.av, cur.tag, "a_value", a_value, cur.av);
            chk(b_value == cur.bv, cur.tag, "b_value", b_value, cur.bv);
            chk(b_addr  == cur.ba, cur.tag, "b_addr", b_addr, cur.ba);
            chk(b_kind  == cur.bk, cur.tag, "b_kind", {13'd0, b_kind}, {13'd0, cur.bk});
            chk(b_writable == cur.bw, cur.tag, "b_writable", {15'd0, b_writable}, {15'd0, cur.bw});
            chk(pc_out  == cur.pc, cur.tag, "pc_out", pc_out, cur.pc);
            chk(sp_out  == cur.sp, cur.tag, "sp_out", sp_out, cur.sp);
            stall_left = cur.stall;
          end
        end else begin
          chk(sp_out == cur.sp && b_value == cur.bv, "R11", "held sp_out", sp_out, cur.sp);
        end
        if (stall_left > 0) begin ack = 1'b0; stall_left--; end
        else ack = 1'b1;
      end else begin
        seen = 0;
        ack = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 16'd1, 16'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready", {15'd0, ready}, 16'd1);
    chk(valid == 1'b0 && mem_req == 1'b0, "R1", "valid/mem_req", {14'd0, valid, mem_req}, 16'd0);
    chk(pc_out == 16'd0 && sp_out == 16'd0, "R1", "pc_out|sp_out", pc_out | sp_out, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(6'h03, 5'h00, 16'h0100, 16'h8000, 16'h0000, 0, "R3");
    drive(6'h07, 5'h06, 16'h0101, 16'h8000, 16'h0000, 1, "R3");
    drive(6'h0a, 5'h0f, 16'h0200, 16'h8000, 16'h0000, 0, "R4");
    drive(6'h12, 5'h15, 16'h0300, 16'h8000, 16'h0000, 0, "R2");
    drive(6'h1a, 5'h1e, 16'h0400, 16'h7000, 16'h0000, 0, "R5");
    drive(6'h18, 5'h18, 16'h0500, 16'hfffe, 16'h0000, 3, "R6");
    drive(6'h21, 5'h18, 16'h0600, 16'h0000, 16'h0000, 0, "R6");
    drive(6'h18, 5'h1b, 16'h0680, 16'hffff, 16'h0000, 0, "R6");
    drive(6'h19, 5'h19, 16'h0700, 16'h1234, 16'h0000, 2, "R7");
    drive(6'h1b, 5'h1c, 16'h0800, 16'h4321, 16'h0000, 0, "R8");
    drive(6'h1d, 5'h1d, 16'h0900, 16'h4321, 16'hbeef, 0, "R8");
    drive(6'h1f, 5'h1c, 16'h0a00, 16'h4321, 16'h0000, 0, "R8");
    drive(6'h20, 5'h1f, 16'h0b00, 16'h4321, 16'h0000, 0, "R10");
    drive(6'h3f, 5'h1f, 16'h0c00, 16'h4321, 16'h0000, 2, "R9");
    drive(6'h1c, 5'h10, 16'h0d00, 16'h4321, 16'h0000, 0, "R5");
    while (exq.size() != 0 || valid || !ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(req_viol == 0, "R12", "back-to-back requests", req_viol[15:0], 16'd0);
    finish_run();
  end

endmodule